// File: doc/BRIEF.md
# UART Receiver with Per-Character Error FIFO

This block turns an asynchronous serial line into received characters. It oversamples the line with a 16x clock-enable strobe and handles 5 to 8 data bits. The parity field can be checked, forced to a fixed value, omitted, or captured as an address/data marker. Each finished character enters a three-entry FIFO together with its own break, framing and parity flags. A holding stage that stands in for the shift register sits in front of the FIFO.

A host reads the head character through `data_o` and removes it by pulsing `pop_i`. A six-bit status word reports the error flags, overrun, FIFO full and character ready. The error flags come in one of two forms. In per-character mode they belong to the head entry. In block mode they are a sticky OR of every character that has entered the FIFO. The interrupt output follows either "character ready" or "FIFO full". Enable, disable, receiver reset and error reset arrive as single-cycle strobes from an outer register decoder.

Top module: `uart_rx_stat`

## Requirements
- R1: `len_sel_i` sets the data width: 0 for 5 bits, 1 for 6 bits, 2 for 7 bits and 3 for 8 bits. Bits arrive LSB first and are presented right-aligned on `data_o`, with the unused upper bits at zero.
- R2: When `par_mode_i`=0, one parity bit follows the data. If `par_odd_i`=0 the parity must be even, and if it is 1 the parity must be odd. A mismatch sets the parity flag, `stat_o[3]`, for that character.
- R3: When `par_mode_i`=1, the parity bit must equal `par_odd_i`. Any other value sets the parity flag.
- R4: When `par_mode_i`=2, no parity bit is expected, the bit after the data is taken as the stop bit, and the parity flag stays clear.
- R5: When `par_mode_i`=3, the extra bit is received and stored unchanged in the parity flag position as an address marker.
- R6: A low stop bit with some nonzero content in the frame stores the character with the framing flag, `stat_o[4]`, set. The receiver then waits for a high line before it looks for a new start bit.
- R7: A frame that samples low throughout, stop bit included, loads exactly one zero character with the break flag, `stat_o[5]`, set. No further character is received until the line returns high.
- R8: The FIFO holds 3 characters in arrival order. `stat_o[0]` is set while at least one character is held, and `stat_o[1]` is set while 3 are held. `pop_i` removes the head entry, and a character parked in the holding stage then moves in behind the others.
- R9: A character that completes while the FIFO is full sets overrun, `stat_o[2]`, and replaces the contents of the holding stage. The FIFO entries stay intact. Overrun is cleared only by error reset or receiver reset; popping does not clear it.
- R10: With `blk_err_i`=0, `stat_o[5:3]` shows the flags of the head entry, or zero when the FIFO is empty, so the flags leave together with their character.
- R11: With `blk_err_i`=1, `stat_o[5:3]` is the OR of the flags of every character that has entered the FIFO since the last clear. It stays set across pops until `err_rst_i` or `rx_rst_i`.
- R12: `irq_o` follows character-ready when `irq_sel_i`=0 and FIFO-full when `irq_sel_i`=1.
- R13: Reception starts disabled after reset. `rx_en_i` turns it on. `rx_dis_i` stops character assembly, while characters already held stay readable.
- R14: `rx_rst_i` empties the FIFO and the holding stage, clears every flag and overrun, and returns the line state machine to idle. After `rst_ni`, `stat_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x oversampling enable |
| rxd_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Enable strobe for the receiver |
| rx_dis_i | input | 1 | Disable strobe for the receiver |
| rx_rst_i | input | 1 | Receiver reset strobe |
| err_rst_i | input | 1 | Error reset strobe |
| len_sel_i | input | 2 | Data width select |
| par_mode_i | input | 2 | Parity mode select |
| par_odd_i | input | 1 | Odd parity select, or the forced parity value |
| blk_err_i | input | 1 | 1 selects block (accumulated) error mode |
| irq_sel_i | input | 1 | Interrupt source select: 0 ready, 1 full |
| pop_i | input | 1 | Remove the head character |
| data_o | output | 8 | Head character |
| stat_o | output | 6 | {break, framing, parity, overrun, full, ready} |
| irq_o | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is overrun with a parked character. Three characters must sit unread in the FIFO, a fourth must land in the holding stage, and a fifth must then overwrite it. The bench builds this by sending five frames back to back without popping. It then drains the FIFO and checks that the pop order skips the fourth character while overrun stays set. Break also needs a line held low for longer than a frame, which the bench drives directly, and it checks that only one character results.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_word_t;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT} rx_state_e;

  localparam logic [1:0] PAR_ON    = 2'b00;
  localparam logic [1:0] PAR_FORCE = 2'b01;
  localparam logic [1:0] PAR_NONE  = 2'b10;
  localparam logic [1:0] PAR_MDROP = 2'b11;
endpackage

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_mode_i,
  input  logic       par_odd_i,
  output logic       done_o,
  output rx_word_t   word_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]  bidx_q;
  logic [7:0]  sh_q;
  logic        pbit_q, allz_q;
  logic [1:0]  sync_q;
  logic        rxd_s;
  logic [2:0]  last_idx;
  logic [7:0]  data_c;
  logic        brk_c, pe_c;

  assign rxd_s    = sync_q[1];
  assign last_idx = {1'b1, len_sel_i};
  assign data_c   = sh_q >> (~len_sel_i);
  assign brk_c    = !rxd_s && allz_q;

  always_comb begin
    unique case (par_mode_i)
      PAR_ON:    pe_c = pbit_q != (^data_c ^ par_odd_i);
      PAR_FORCE: pe_c = pbit_q != par_odd_i;
      PAR_MDROP: pe_c = pbit_q;
      default:   pe_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; cnt_q <= '0; bidx_q <= '0; sh_q <= '0;
      pbit_q <= 1'b0; allz_q <= 1'b0; sync_q <= 2'b11;
      done_o <= 1'b0; word_o <= '0;
    end else begin
      done_o <= 1'b0;
      sync_q <= {sync_q[0], rxd_i};
      if (clr_i || !run_i) begin
        st_q <= S_IDLE; cnt_q <= '0;
      end else if (tick_i) begin
        unique case (st_q)
          S_IDLE: if (!rxd_s) begin st_q <= S_START; cnt_q <= '0; end
          S_START: begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              if (!rxd_s) begin
                st_q <= S_DATA; sh_q <= '0; allz_q <= 1'b1; bidx_q <= '0; pbit_q <= 1'b0;
              end else st_q <= S_IDLE;  // glitch, not a start bit
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              sh_q   <= {rxd_s, sh_q[7:1]};
              allz_q <= allz_q & ~rxd_s;
              bidx_q <= bidx_q + 1'b1;
              if (bidx_q == last_idx) st_q <= (par_mode_i == PAR_NONE) ? S_STOP : S_PAR;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0; pbit_q <= rxd_s; allz_q <= allz_q & ~rxd_s; st_q <= S_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              done_o <= 1'b1;
              word_o.brk  <= brk_c;
              word_o.fe   <= !rxd_s && !allz_q;
              word_o.pe   <= brk_c ? 1'b0 : pe_c;
              word_o.data <= brk_c ? 8'h00 : data_c;
              st_q <= rxd_s ? S_IDLE : S_WAIT;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_WAIT: if (rxd_s) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  // R7
  brk_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && word_o.brk |-> word_o.data == 8'h00 && !word_o.fe);
  // R1
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 11,
  parameter int NFLAG = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          flag_clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic          pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok = pop_i && (cnt_o != '0);
  assign head_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; cnt_o <= '0;
    end else begin
      if (flag_clr_i)
        for (int i = 0; i < DEPTH; i++) mem_q[i][W-1 -: NFLAG] <= '0;
      if (push_i) begin
        mem_q[wp_q] <= wdata_i;
        wp_q <= nxt(wp_q);
      end
      if (pop_ok) rp_q <= nxt(rp_q);
      cnt_o <= cnt_o + CW'(push_i) - CW'(pop_ok);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_o < CW'(DEPTH));
  // R8
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int OVS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       rx_en_i,
  input  logic       rx_dis_i,
  input  logic       rx_rst_i,
  input  logic       err_rst_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_mode_i,
  input  logic       par_odd_i,
  input  logic       blk_err_i,
  input  logic       irq_sel_i,
  input  logic       pop_i,
  output logic [7:0] data_o,
  output logic [5:0] stat_o,
  output logic       irq_o
);
  localparam int W  = $bits(rx_word_t);
  localparam int CW = $clog2(DEPTH + 1);

  logic          en_q, hold_v, ovr_q, done;
  logic [2:0]    acc_q, flags;
  rx_word_t      new_w, hold_q, wdata, head;
  logic [CW-1:0] cnt;
  logic          full, rdy, push_new, drain, push, err_clr;

  rx_frame #(.OVS(OVS)) i_frame (
    .clk_i, .rst_ni, .clr_i(rx_rst_i), .run_i(en_q), .tick_i, .rxd_i,
    .len_sel_i, .par_mode_i, .par_odd_i, .done_o(done), .word_o(new_w)
  );

  assign full     = cnt == CW'(DEPTH);
  assign rdy      = cnt != '0;
  assign push_new = done && !hold_v && !full;
  assign drain    = hold_v && !full;
  assign push     = push_new || drain;
  assign wdata    = drain ? hold_q : new_w;
  assign err_clr  = err_rst_i || rx_rst_i;

  rx_fifo #(.DEPTH(DEPTH), .W(W), .NFLAG(3)) i_fifo (
    .clk_i, .rst_ni, .clr_i(rx_rst_i), .flag_clr_i(err_rst_i),
    .push_i(push), .wdata_i(wdata), .pop_i, .head_o(head), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; hold_v <= 1'b0; hold_q <= '0; ovr_q <= 1'b0; acc_q <= '0;
    end else begin
      if (rx_en_i) en_q <= 1'b1;
      else if (rx_dis_i) en_q <= 1'b0;
      if (rx_rst_i) begin
        hold_v <= 1'b0; ovr_q <= 1'b0; acc_q <= '0;
      end else begin
        if (err_rst_i) begin
          hold_q.brk <= 1'b0; hold_q.fe <= 1'b0; hold_q.pe <= 1'b0;
        end
        if (done && !push_new) begin  // park or overwrite the holding stage
          hold_q <= new_w; hold_v <= 1'b1;
        end else if (drain) hold_v <= 1'b0;
        if (err_rst_i) ovr_q <= 1'b0;
        else if (done && full) ovr_q <= 1'b1;
        if (err_rst_i) acc_q <= '0;
        else if (push) acc_q <= acc_q | {wdata.brk, wdata.fe, wdata.pe};
      end
    end
  end

  assign flags  = blk_err_i ? acc_q : (rdy ? {head.brk, head.fe, head.pe} : 3'b000);
  assign stat_o = {flags, ovr_q, full, rdy};
  assign data_o = head.data;
  assign irq_o  = irq_sel_i ? full : rdy;

  // R9
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(cnt == CW'(DEPTH)));
  // R9
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !err_clr |=> ovr_q);
  // R12
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == '0 |-> !irq_o);
  // R14
  rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_i |=> cnt == '0 && !ovr_q && acc_q == 3'b000);
  // R11
  acc_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acc_q) && !err_clr |=> (|acc_q));
endmodule

// File: tb/test_uart_rx_stat.sv
module test_uart_rx_stat;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic rxd = 1'b1, rx_en = 1'b0, rx_dis = 1'b0, rx_rst = 1'b0, err_rst = 1'b0;
  logic [1:0] len_sel = 2'd3, par_mode = 2'd2;
  logic par_odd = 1'b0, blk = 1'b0, irq_sel = 1'b0, pop = 1'b0;
  logic [7:0] data_o;
  logic [5:0] stat_o;
  logic irq_o;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  uart_rx_stat i_uart_rx_stat (
    .clk_i(clk), .rst_ni, .tick_i(1'b1), .rxd_i(rxd), .rx_en_i(rx_en), .rx_dis_i(rx_dis),
    .rx_rst_i(rx_rst), .err_rst_i(err_rst), .len_sel_i(len_sel), .par_mode_i(par_mode),
    .par_odd_i(par_odd), .blk_err_i(blk), .irq_sel_i(irq_sel), .pop_i(pop),
    .data_o, .stat_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit use_par, input bit pb, input bit stopb);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (use_par) line_bit(pb);
    line_bit(stopb);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe_err();
    @(negedge clk) err_rst = 1'b1;
    @(negedge clk) err_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R14 reset stat", stat_o, 6'h00);
    chk("R14 reset irq", irq_o, 1'b0);
    send(8'h5A, 8, 0, 0, 1);
    chk("R13 disabled after reset", stat_o[0], 1'b0);
    @(negedge clk) rx_en = 1'b1;
    @(negedge clk) rx_en = 1'b0;
  endtask

  task automatic t_len();
    par_mode = 2'd2;
    for (int l = 0; l < 4; l++) begin
      len_sel = 2'(l);
      send(8'hB6, 5 + l, 0, 0, 1);
      chk("R1 ready", stat_o[0], 1'b1);
      chk("R1 data", data_o, 8'hB6 & 8'((1 << (5 + l)) - 1));
      do_pop();
    end
    len_sel = 2'd3;
  endtask

  task automatic t_par();
    par_mode = 2'd0; par_odd = 1'b0;
    send(8'h35, 8, 1, 0, 1); chk("R2 even ok", stat_o[3], 1'b0); do_pop();
    send(8'h35, 8, 1, 1, 1); chk("R2 even bad", stat_o[3], 1'b1);
    chk("R2 data", data_o, 8'h35); do_pop();
    par_odd = 1'b1;
    send(8'h35, 8, 1, 1, 1); chk("R2 odd ok", stat_o[3], 1'b0); do_pop();
  endtask

  task automatic t_force();
    par_mode = 2'd1; par_odd = 1'b1;
    send(8'h35, 8, 1, 1, 1); chk("R3 forced one ok", stat_o[3], 1'b0); do_pop();
    send(8'h35, 8, 1, 0, 1); chk("R3 forced one bad", stat_o[3], 1'b1); do_pop();
    par_odd = 1'b0;
    send(8'h35, 8, 1, 0, 1); chk("R3 forced zero ok", stat_o[3], 1'b0); do_pop();
  endtask

  task automatic t_nopar();
    par_mode = 2'd2;
    send(8'hFE, 8, 0, 0, 1);
    chk("R4 data", data_o, 8'hFE);
    chk("R4 flags", stat_o[5:3], 3'b000);
    do_pop();
  endtask

  task automatic t_mdrop();
    par_mode = 2'd3;
    send(8'h42, 8, 1, 1, 1); chk("R5 address mark", stat_o[3], 1'b1);
    chk("R5 data", data_o, 8'h42); do_pop();
    send(8'h43, 8, 1, 0, 1); chk("R5 data mark", stat_o[3], 1'b0); do_pop();
  endtask

  task automatic t_frame();
    par_mode = 2'd2;
    send(8'h55, 8, 0, 0, 0);
    chk("R6 framing", stat_o[5:4], 2'b01);
    chk("R6 data", data_o, 8'h55);
    do_pop();
    chk("R6 one char", stat_o[0], 1'b0);
  endtask

  task automatic t_break();
    par_mode = 2'd2;
    rxd = 1'b0;
    repeat (16 * 10 + 80) @(negedge clk);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7 break flag", stat_o[5:4], 2'b10);
    chk("R7 zero data", data_o, 8'h00);
    do_pop();
    chk("R7 single char", stat_o[0], 1'b0);
  endtask

  task automatic t_fifo();
    par_mode = 2'd2; irq_sel = 1'b1;
    send(8'hA1, 8, 0, 0, 1);
    chk("R12 full-select one char", irq_o, 1'b0);
    irq_sel = 1'b0; #1;
    chk("R12 ready-select", irq_o, 1'b1);
    send(8'hA2, 8, 0, 0, 1);
    send(8'hA3, 8, 0, 0, 1);
    chk("R8 full", stat_o[1:0], 2'b11);
    irq_sel = 1'b1; #1;
    chk("R12 full-select full", irq_o, 1'b1);
    chk("R9 no overrun yet", stat_o[2], 1'b0);
    send(8'hA4, 8, 0, 0, 1);
    chk("R9 overrun set", stat_o[2], 1'b1);
    send(8'hA5, 8, 0, 0, 1);
    chk("R9 head kept", data_o, 8'hA1);
    do_pop(); chk("R8 order 2", data_o, 8'hA2);
    do_pop(); chk("R8 order 3", data_o, 8'hA3);
    do_pop(); chk("R9 newest kept", data_o, 8'hA5);
    do_pop(); chk("R8 empty", stat_o[1:0], 2'b00);
    chk("R9 overrun survives pops", stat_o[2], 1'b1);
    strobe_err();
    chk("R9 overrun cleared", stat_o[2], 1'b0);
    irq_sel = 1'b0;
  endtask

  task automatic t_charmode();
    blk = 1'b0; par_mode = 2'd0; par_odd = 1'b0;
    send(8'h35, 8, 1, 1, 1);
    send(8'h36, 8, 1, 0, 1);
    chk("R10 head flag", stat_o[3], 1'b1);
    do_pop(); chk("R10 flag dropped", stat_o[3], 1'b0);
    do_pop();
  endtask

  task automatic t_block();
    strobe_err();
    blk = 1'b1; par_mode = 2'd0; par_odd = 1'b0;
    send(8'h35, 8, 1, 1, 1);
    send(8'h36, 8, 1, 0, 1);
    do_pop(); chk("R11 sticky after pop", stat_o[3], 1'b1);
    do_pop(); chk("R11 sticky when empty", stat_o[3], 1'b1);
    strobe_err();
    chk("R11 cleared", stat_o[3], 1'b0);
    blk = 1'b0;
  endtask

  task automatic t_disable();
    par_mode = 2'd2;
    send(8'h11, 8, 0, 0, 1);
    @(negedge clk) rx_dis = 1'b1;
    @(negedge clk) rx_dis = 1'b0;
    send(8'h22, 8, 0, 0, 1);
    chk("R13 held char", data_o, 8'h11);
    do_pop(); chk("R13 nothing new", stat_o[0], 1'b0);
    @(negedge clk) rx_en = 1'b1;
    @(negedge clk) rx_en = 1'b0;
    send(8'h33, 8, 0, 0, 1);
    chk("R13 re-enabled", data_o, 8'h33);
    do_pop();
  endtask

  task automatic t_rxrst();
    par_mode = 2'd0; par_odd = 1'b0;
    send(8'h01, 8, 1, 0, 1);
    send(8'h02, 8, 1, 0, 1);
    send(8'h03, 8, 1, 0, 1);
    send(8'h04, 8, 1, 0, 1);
    chk("R14 precondition", stat_o[2:0], 3'b111);
    @(negedge clk) rx_rst = 1'b1;
    @(negedge clk) rx_rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R14 cleared", stat_o, 6'h00);
    chk("R14 irq low", irq_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset(); t_len(); t_par(); t_force(); t_nopar(); t_mdrop();
    t_frame(); t_break(); t_fifo(); t_charmode(); t_block();
    t_disable(); t_rxrst();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule